// File: doc/BRIEF.md
# LPC Flash Program-and-Poll Sequencer

This block is the host side of a one-byte flash program or erase operation on an LPC bus. When it accepts a request, it runs one LPC memory-write cycle. That cycle carries the command byte to the 32-bit target address. The block then runs LPC memory-read cycles at the same address until the target reports that its internal write has finished. It makes that decision from bit 7 of each returned byte. While the target is still busy, bit 7 is the complement of bit 7 of the byte that was written. Once the target has finished, bit 7 equals it. No status register is read.

The block owns the frame strobe. LAD is split into three plain signals: an output nibble, an output enable and an input nibble. The block drives LAD during the host phases of each cycle and releases it for the target phases. It reads the sync code and the read data from the input nibble. The operation ends with one of three flags: done, timeout or sync error. The flag stays set until the next request is accepted. A request is taken only while the block is idle.

Top module: `lpc_pp_top`

## Requirements
- R1: While reset is active and after it is released, with no request pending, `lframe_n` is 1, `lad_oe` is 0, and `done`, `timeout` and `sync_err` are 0.
- R2: Every bus cycle begins with one clock in which `lframe_n` is 0 and `lad_out` is 0000b. In the next clock `lframe_n` is 1 and `lad_out` carries the cycle code: 0110b for the memory write, 0100b for each memory read.
- R3: After the cycle code the host drives the 8 address nibbles, bits 31:28 first and bits 3:0 last. On a write it then drives the two data nibbles, bits 3:0 before bits 7:4.
- R4: After the address or write data, the host drives 1111b for one clock and then sets `lad_oe` to 0. `lad_oe` stays 0 through sync, read data and the two closing turnaround clocks.
- R5: From the clock after the turnaround, the host samples `lad_in` for the sync code 0000b for at most SYNC_WAIT clocks. If 0000b does not appear in that window, the operation stops, the block returns to idle and `sync_err` is set.
- R6: On a read, the two clocks after the sync clock carry data bits 3:0 and then bits 7:4. If bit 7 of that byte equals bit 7 of the written byte, the operation finishes with `done` set.
- R7: The next cycle's start clock directly follows the second closing turnaround clock. The write is followed by a read, and a read without a match is followed by another read to the same address.
- R8: After POLL_LIMIT reads without a match, the block sets `timeout` and returns to idle with no further cycle.
- R9: Accepting a request clears all three flags. `req_valid` is ignored while an operation is in progress.
- R10: At most one of `done`, `timeout` and `sync_err` is 1 at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start request, taken when idle |
| req_addr | input | 32 | Target byte address |
| req_data | input | 8 | Program or erase command byte |
| lad_in | input | 4 | LAD value seen on the bus |
| lad_out | output | 4 | LAD value driven by the host |
| lad_oe | output | 1 | Host drives LAD when 1 |
| lframe_n | output | 1 | Frame strobe, active low |
| done | output | 1 | Bit-7 match seen |
| timeout | output | 1 | Poll limit reached |
| sync_err | output | 1 | No sync within SYNC_WAIT clocks |

## Verification
The bench builds the block with POLL_LIMIT = 4 and SYNC_WAIT = 3. This keeps poll exhaustion reachable after a handful of reads. It also allows a sync that arrives on the last allowed clock to be tested next to one that never arrives. Sync aborts are tested both on the write and on a later read. Some operations end with an immediate match and some with a delayed match. A stray request is held high during a busy operation to show that it has no effect.

// File: rtl/lpc_pp_pkg.sv
package lpc_pp_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_START, ST_CYC, ST_ADDR, ST_WDAT, ST_TAR_H, ST_TAR_R,
    ST_SYNC, ST_RDAT, ST_TAR_T1, ST_TAR_T2
  } pp_state_e;

  localparam logic [3:0] NIB_START = 4'b0000;
  localparam logic [3:0] CODE_MWR  = 4'b0110;
  localparam logic [3:0] CODE_MRD  = 4'b0100;
  localparam logic [3:0] NIB_TAR   = 4'b1111;
  localparam logic [3:0] NIB_READY = 4'b0000;
endpackage

// File: rtl/lpc_pp_rstsync.sv
module lpc_pp_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic meta;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta    <= 1'b0;
      rst_n_s <= 1'b0;
    end else begin
      meta    <= 1'b1;
      rst_n_s <= meta;
    end
  end
endmodule

// File: rtl/lpc_pp_cnt.sv
module lpc_pp_cnt #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nx;
  always_comb begin
    q_nx = q;
    if (clr)      q_nx = '0;
    else if (inc) q_nx = q + 1'b1;
  end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          q <= '0;
    else if (clr || inc) q <= q_nx;
  end
endmodule

// File: rtl/lpc_pp_ctrl.sv
module lpc_pp_ctrl
  import lpc_pp_pkg::*;
#(
  parameter int POLL_LIMIT = 4096,
  parameter int SYNC_WAIT  = 8
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      req_valid,
  input  logic [3:0] lad_in,
  input  logic      wbit7,
  output pp_state_e state,
  output logic [2:0] sub,
  output logic      rd_cyc,
  output logic      accept,
  output logic      done,
  output logic      timeout,
  output logic      sync_err
);
  localparam int PW = $clog2(POLL_LIMIT + 1);
  localparam int SW = $clog2(SYNC_WAIT + 1);
  localparam logic [PW-1:0] POLL_LAST = PW'(POLL_LIMIT - 1);
  localparam logic [SW-1:0] SYNC_LAST = SW'(SYNC_WAIT - 1);

  pp_state_e state_nx;
  logic [PW-1:0] pcnt;
  logic [SW-1:0] wcnt;
  logic sub_clr, sub_inc, wcnt_clr, wcnt_inc, pcnt_clr, pcnt_inc;
  logic rd_set, mflag_ld, mflag;
  logic done_set, to_set, err_set;

  lpc_pp_cnt #(.W(3))  u_sub  (.clk(clk), .rst_n(rst_n), .clr(sub_clr),  .inc(sub_inc),  .q(sub));
  lpc_pp_cnt #(.W(SW)) u_wcnt (.clk(clk), .rst_n(rst_n), .clr(wcnt_clr), .inc(wcnt_inc), .q(wcnt));
  lpc_pp_cnt #(.W(PW)) u_pcnt (.clk(clk), .rst_n(rst_n), .clr(pcnt_clr), .inc(pcnt_inc), .q(pcnt));

  always_comb begin
    state_nx = state;
    sub_clr = 1'b0;  sub_inc = 1'b0;
    wcnt_clr = 1'b0; wcnt_inc = 1'b0;
    pcnt_clr = 1'b0; pcnt_inc = 1'b0;
    rd_set = 1'b0;   mflag_ld = 1'b0;
    done_set = 1'b0; to_set = 1'b0; err_set = 1'b0;
    accept = 1'b0;
    case (state)
      ST_IDLE: if (req_valid) begin
        accept = 1'b1; pcnt_clr = 1'b1; state_nx = ST_START;
      end
      ST_START: state_nx = ST_CYC;
      ST_CYC: begin sub_clr = 1'b1; state_nx = ST_ADDR; end
      ST_ADDR: if (sub == 3'd7) begin
        sub_clr = 1'b1; state_nx = rd_cyc ? ST_TAR_H : ST_WDAT;
      end else sub_inc = 1'b1;
      ST_WDAT: if (sub[0]) begin
        sub_clr = 1'b1; state_nx = ST_TAR_H;
      end else sub_inc = 1'b1;
      ST_TAR_H: state_nx = ST_TAR_R;
      ST_TAR_R: begin wcnt_clr = 1'b1; state_nx = ST_SYNC; end
      ST_SYNC: if (lad_in == NIB_READY) begin
        sub_clr = 1'b1; state_nx = rd_cyc ? ST_RDAT : ST_TAR_T1;
      end else if (wcnt == SYNC_LAST) begin
        err_set = 1'b1; state_nx = ST_IDLE;
      end else wcnt_inc = 1'b1;
      ST_RDAT: if (sub[0]) begin
        mflag_ld = 1'b1; sub_clr = 1'b1; state_nx = ST_TAR_T1;
      end else sub_inc = 1'b1;
      ST_TAR_T1: state_nx = ST_TAR_T2;
      ST_TAR_T2: if (!rd_cyc) begin
        rd_set = 1'b1; state_nx = ST_START;
      end else if (mflag) begin
        done_set = 1'b1; state_nx = ST_IDLE;
      end else if (pcnt == POLL_LAST) begin
        to_set = 1'b1; state_nx = ST_IDLE;
      end else begin
        pcnt_inc = 1'b1; state_nx = ST_START;
      end
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      rd_cyc <= 1'b0;
      mflag <= 1'b0;
      done <= 1'b0;
      timeout <= 1'b0;
      sync_err <= 1'b0;
    end else begin
      state <= state_nx;
      if (accept || rd_set) rd_cyc <= rd_set;
      if (mflag_ld) mflag <= (lad_in[3] == wbit7);
      if (accept || done_set) done <= done_set;
      if (accept || to_set) timeout <= to_set;
      if (accept || err_set) sync_err <= err_set;
    end
  end

  p_flags_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, timeout, sync_err}));
  p_clear_on_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !done && !timeout && !sync_err);
  p_sync_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SYNC) |-> (wcnt < SW'(SYNC_WAIT)));
  p_poll_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt < PW'(POLL_LIMIT));
  p_done_after_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(state == ST_TAR_T2) && $past(rd_cyc));
  p_back_to_back_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TAR_T2 && !rd_cyc) |=> state == ST_START);
endmodule

// File: rtl/lpc_pp_frame.sv
module lpc_pp_frame
  import lpc_pp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept,
  input  logic [31:0] req_addr,
  input  logic [7:0] req_data,
  input  pp_state_e  state,
  input  logic [2:0] sub,
  input  logic       rd_cyc,
  output logic [3:0] lad_out,
  output logic       lad_oe,
  output logic       lframe_n,
  output logic       wbit7
);
  logic [31:0] addr_q;
  logic [7:0]  data_q;
  logic [2:0]  a_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (accept) begin
      addr_q <= req_addr;
      data_q <= req_data;
    end
  end

  assign wbit7 = data_q[7];
  assign a_idx = 3'd7 - sub;

  always_comb begin
    lframe_n = 1'b1;
    lad_oe   = 1'b0;
    lad_out  = 4'b0000;
    case (state)
      ST_START: begin lframe_n = 1'b0; lad_oe = 1'b1; lad_out = NIB_START; end
      ST_CYC:   begin lad_oe = 1'b1; lad_out = rd_cyc ? CODE_MRD : CODE_MWR; end
      ST_ADDR:  begin lad_oe = 1'b1; lad_out = addr_q[{a_idx, 2'b00} +: 4]; end
      ST_WDAT:  begin lad_oe = 1'b1; lad_out = data_q[{sub[0], 2'b00} +: 4]; end
      ST_TAR_H: begin lad_oe = 1'b1; lad_out = NIB_TAR; end
      default:  begin lad_oe = 1'b0; lad_out = 4'b0000; end
    endcase
  end

  p_frame_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !lframe_n |=> lframe_n);
  p_code_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !lframe_n |=> lad_oe && (lad_out == CODE_MWR || lad_out == CODE_MRD));
  p_release_after_tar_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TAR_H) |=> !lad_oe && lframe_n);
endmodule

// File: rtl/lpc_pp_top.sv
module lpc_pp_top #(
  parameter int POLL_LIMIT = 4096,
  parameter int SYNC_WAIT  = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [31:0] req_addr,
  input  logic [7:0]  req_data,
  input  logic [3:0]  lad_in,
  output logic [3:0]  lad_out,
  output logic        lad_oe,
  output logic        lframe_n,
  output logic        done,
  output logic        timeout,
  output logic        sync_err
);
  logic rst_n_s, accept, rd_cyc, wbit7;
  logic [2:0] sub;
  lpc_pp_pkg::pp_state_e state;

  lpc_pp_rstsync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_s(rst_n_s));

  lpc_pp_ctrl #(.POLL_LIMIT(POLL_LIMIT), .SYNC_WAIT(SYNC_WAIT)) u_ctrl (
    .clk(clk), .rst_n(rst_n_s), .req_valid(req_valid), .lad_in(lad_in),
    .wbit7(wbit7), .state(state), .sub(sub), .rd_cyc(rd_cyc), .accept(accept),
    .done(done), .timeout(timeout), .sync_err(sync_err));

  lpc_pp_frame u_frame (
    .clk(clk), .rst_n(rst_n_s), .accept(accept), .req_addr(req_addr),
    .req_data(req_data), .state(state), .sub(sub), .rd_cyc(rd_cyc),
    .lad_out(lad_out), .lad_oe(lad_oe), .lframe_n(lframe_n), .wbit7(wbit7));
endmodule

// File: tb/lpc_pp_top_tb.sv
module lpc_pp_top_tb;
  localparam int PL = 4;
  localparam int SW = 3;

  logic clk, rst_n, req_valid;
  logic [31:0] req_addr;
  logic [7:0] req_data;
  logic [3:0] lad_in, lad_out;
  logic lad_oe, lframe_n, done, timeout, sync_err;
  int checks, fails;

  typedef struct {
    bit fr; bit oe; logic [3:0] lad; logic [3:0] lin;
    bit dn; bit to; bit er; string tag;
  } ent_t;
  ent_t q[$];

  lpc_pp_top #(.POLL_LIMIT(PL), .SYNC_WAIT(SW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_data(req_data), .lad_in(lad_in), .lad_out(lad_out), .lad_oe(lad_oe),
    .lframe_n(lframe_n), .done(done), .timeout(timeout), .sync_err(sync_err));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic push(bit fr, bit oe, logic [3:0] lad, logic [3:0] lin, string tag);
    ent_t e;
    e.fr = fr; e.oe = oe; e.lad = lad; e.lin = lin;
    e.dn = 0; e.to = 0; e.er = 0; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic push_end(bit dn, bit to, bit er, string tag);
    ent_t e;
    e.fr = 1; e.oe = 0; e.lad = 0; e.lin = 4'hF;
    e.dn = dn; e.to = to; e.er = er; e.tag = tag;
    q.push_back(e);
  endtask

  // One bus cycle seen from the host; ab=1 if the sync never comes.
  task automatic add_cycle(bit rd, logic [31:0] a, logic [7:0] d, int sw,
                           logic [7:0] rb, output bit ab);
    ab = 0;
    push(0, 1, 4'h0, 4'hF, rd ? "R7" : "R2");
    push(1, 1, rd ? 4'h4 : 4'h6, 4'hF, "R2");
    for (int i = 7; i >= 0; i--) push(1, 1, a[i*4 +: 4], 4'hF, "R3");
    if (!rd) begin
      push(1, 1, d[3:0], 4'hF, "R3");
      push(1, 1, d[7:4], 4'hF, "R3");
    end
    push(1, 1, 4'hF, 4'hF, "R4");
    push(1, 0, 4'h0, 4'hF, "R4");
    if (sw >= SW) begin
      for (int k = 0; k < SW; k++) push(1, 0, 4'h0, 4'h6, "R5");
      ab = 1;
      return;
    end
    for (int k = 0; k < sw; k++) push(1, 0, 4'h0, 4'h6, "R5");
    push(1, 0, 4'h0, 4'h0, "R5");
    if (rd) begin
      push(1, 0, 4'h0, rb[3:0], "R6");
      push(1, 0, 4'h0, rb[7:4], "R6");
    end
    push(1, 0, 4'h0, 4'hF, "R4");
    push(1, 0, 4'h0, 4'hF, "R4");
  endtask

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Plays the queue, one entry per clock, comparing at the falling edge.
  task automatic run(logic [31:0] a, logic [7:0] d, int noisy);
    int n;
    n = 0;
    @(negedge clk);
    req_valid = 1; req_addr = a; req_data = d;
    @(negedge clk);
    while (q.size() > 0) begin
      ent_t e;
      e = q.pop_front();
      lad_in = e.lin;
      req_valid = (n < noisy) ? 1'b1 : 1'b0; // R9: ignored while busy
      req_addr = ~a; req_data = ~d;
      check(e.tag, "lframe_n", lframe_n, e.fr);
      check(e.tag, "lad_oe", lad_oe, e.oe);
      if (e.oe) check(e.tag, "lad_out", lad_out, e.lad);
      check(n == 0 ? "R9" : e.tag, "done", done, e.dn);
      check(n == 0 ? "R9" : e.tag, "timeout", timeout, e.to);
      check(n == 0 ? "R9" : e.tag, "sync_err", sync_err, e.er);
      n++;
      @(negedge clk);
    end
    req_valid = 0;
    lad_in = 4'hF;
  endtask

  initial begin
    bit ab;
    checks = 0; fails = 0;
    rst_n = 0; req_valid = 0; req_addr = 0; req_data = 0; lad_in = 4'hF;
    repeat (3) @(negedge clk);
    check("R1", "lframe_n in reset", lframe_n, 1);
    check("R1", "lad_oe in reset", lad_oe, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check("R1", "lframe_n idle", lframe_n, 1);
    check("R1", "lad_oe idle", lad_oe, 0);
    check("R1", "flags idle", {done, timeout, sync_err}, 0);

    // R6: delayed match on the second read
    add_cycle(0, 32'hFFBC_1234, 8'hA5, 0, 8'h00, ab);
    add_cycle(1, 32'hFFBC_1234, 8'hA5, 1, 8'h25, ab);
    add_cycle(1, 32'hFFBC_1234, 8'hA5, 2, 8'hA5, ab);
    push_end(1, 0, 0, "R6");
    run(32'hFFBC_1234, 8'hA5, 0);

    // R9: stray request during busy; R5: sync on last allowed clock
    add_cycle(0, 32'h0000_7F0E, 8'h3C, 2, 8'h00, ab);
    add_cycle(1, 32'h0000_7F0E, 8'h3C, 0, 8'h3C, ab);
    push_end(1, 0, 0, "R6");
    run(32'h0000_7F0E, 8'h3C, 20);

    // R8: poll limit exhausted
    add_cycle(0, 32'h1357_9BDF, 8'h80, 0, 8'h00, ab);
    for (int i = 0; i < PL; i++) add_cycle(1, 32'h1357_9BDF, 8'h80, 0, 8'h7F, ab);
    push_end(0, 1, 0, "R8");
    run(32'h1357_9BDF, 8'h80, 0);

    // R5: no sync on the write
    add_cycle(0, 32'hC0DE_0042, 8'h10, SW, 8'h00, ab);
    push_end(0, 0, 1, "R5");
    run(32'hC0DE_0042, 8'h10, 0);

    // R5: no sync on a later read
    add_cycle(0, 32'h2468_ACE1, 8'h80, 1, 8'h00, ab);
    add_cycle(1, 32'h2468_ACE1, 8'h80, 0, 8'h00, ab);
    add_cycle(1, 32'h2468_ACE1, 8'h80, SW, 8'h00, ab);
    push_end(0, 0, 1, "R5");
    run(32'h2468_ACE1, 8'h80, 0);

    // R9: flags cleared by new request; immediate match with bit 7 = 0
    add_cycle(0, 32'h8000_0001, 8'h01, 0, 8'h00, ab);
    add_cycle(1, 32'h8000_0001, 8'h01, 0, 8'h7E, ab);
    push_end(1, 0, 0, "R9");
    run(32'h8000_0001, 8'h01, 0);

    repeat (3) @(negedge clk);
    check("R1", "idle after run", {lframe_n, lad_oe}, 2'b10);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule